// File: doc/BRIEF.md
# Reflected CRC-16 generator

This block computes the 16-bit check word that protects binary-mode serial frames. Bytes are offered one at a time with a valid strobe. Each accepted byte is folded into a 16-bit register that starts at all ones. The register shifts toward its least significant end, and the reflected polynomial A001H is XORed in whenever a one drops out.

The running value is always on the outputs, together with its two bytes already split into the order they go out on the line: low byte first, then high byte. A transmitter can append these two bytes to its frame. A receiver can instead feed the two received check bytes through the same register and watch for a zero residue, which raises a match flag.

A build parameter selects one of two variants:

- **Bit-serial:** one shift step per clock, eight busy cycles per byte, and a ready/busy handshake.
- **Unrolled:** all eight steps in one clock; the result appears on the cycle after the byte is taken.

A start-of-frame pulse presets the register for the next frame.

Top module: `crc16r_engine`

## Requirements
- R1: After reset, crc_value is FFFFH, busy is 0, ready is 1 and match is 0.
- R2: For each accepted byte, the byte is XORed into bits 7..0 of the register. Eight steps then follow. Each step shifts the register right by one. If the bit shifted out of bit 0 was 1, the step also XORs the result with A001H. From a preset register, a single byte gives exactly this arithmetic result.
- R3: After a start-of-frame pulse, the bytes 02H then 07H leave crc_value at 1241H.
- R4: tx_first always carries crc_value bits 7..0 and tx_second carries bits 15..8. For 1241H they read 41H and 12H.
- R5: In the bit-serial variant, busy goes high on the cycle after a byte is accepted and stays high for exactly 8 cycles. ready is the inverse of busy.
- R6: In the bit-serial variant, a byte presented while busy is high is ignored, and the result equals that of the earlier byte alone.
- R7: sof presets the register to FFFFH and aborts any byte in progress, so busy is 0 on the next cycle. A byte presented in the same cycle as sof is dropped.
- R8: In the unrolled variant, busy never rises. The full byte result is on crc_value on the cycle after acceptance.
- R9: Feeding a frame followed by its two check bytes (low byte first) leaves a residue of 0000H. match is 1 exactly when busy is 0 and crc_value is 0000H.
- R10: With no accepted byte and no sof, crc_value holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start of frame: preset register, abort byte in progress |
| in_valid | input | 1 | in_data holds a byte to fold in |
| in_data | input | 8 | Data byte |
| ready | output | 1 | A byte can be accepted this cycle |
| busy | output | 1 | Bit-serial variant is still shifting the last byte |
| crc_value | output | 16 | Current register contents (final when ready) |
| tx_first | output | 8 | Check byte sent first (low half) |
| tx_second | output | 8 | Check byte sent second (high half) |
| match | output | 1 | Register idle and equal to zero (received frame checks) |

## Verification

All 256 single-byte frames are swept through both variants at once and compared with an arithmetic model. This catches a wrong polynomial, a left shift, a flag taken from the wrong end of the register, or a step count other than eight. The same sweep measures the length of the busy window, so an off-by-one counter that stops after seven or nine steps shows up directly.

The 02H, 07H vector and its residue run catch check bytes emitted in the wrong order, since the swapped pair 12H, 41H leaves a non-zero residue. Targeted cases cover:

- a byte offered while busy, which a design without gating would absorb;
- sof arriving mid-byte, where a design that lets the count run on would leave busy high or leave a partial value;
- sof coinciding with valid, which a design with the wrong priority would fold into the new frame.

// File: rtl/crc16r_pkg.sv
// Shared widths and word types for the reflected CRC-16 engine.
// Assumes byte-wide input and a 16-bit check word.
package crc16r_pkg;
    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;
    typedef logic [CRC_W-1:0]  crc_word_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/crc16r_step.sv
// One shift-right step of the reflected CRC: shift by one, then XOR the
// polynomial if the bit leaving bit 0 was set. Purely combinational.
module crc16r_step
    import crc16r_pkg::*;
#(
    parameter crc_word_t POLY = 16'hA001
) (
    input  crc_word_t cur,
    output crc_word_t nxt
);
    // shift and conditional polynomial fold
    always_comb begin
        nxt = cur >> 1;
        if (cur[0]) nxt = nxt ^ POLY;
    end
endmodule

// File: rtl/crc16r_unroll.sv
// Folds a byte into the register and chains STEPS single steps in one
// combinational path. Assumes STEPS equals the byte width.
module crc16r_unroll
    import crc16r_pkg::*;
#(
    parameter crc_word_t POLY  = 16'hA001,
    parameter int        STEPS = BYTE_W
) (
    input  crc_word_t cur,
    input  byte_t     data,
    output crc_word_t nxt
);
    crc_word_t chain [STEPS+1];

    assign chain[0] = cur ^ {{(CRC_W-BYTE_W){1'b0}}, data};

    genvar i;
    generate
        for (i = 0; i < STEPS; i++) begin : g_step
            crc16r_step #(.POLY(POLY)) u_step (
                .cur(chain[i]),
                .nxt(chain[i+1])
            );
        end
    endgenerate

    assign nxt = chain[STEPS];
endmodule

// File: rtl/crc16r_serial_core.sv
// Bit-serial register: an accepted byte is XORed in, then one step per
// clock for BYTE_W clocks while busy is high. Assumes accept is only
// raised while busy is low, and that sof has priority over everything.
module crc16r_serial_core
    import crc16r_pkg::*;
#(
    parameter crc_word_t POLY   = 16'hA001,
    parameter crc_word_t PRESET = 16'hFFFF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sof,
    input  logic      accept,
    input  byte_t     data,
    output crc_word_t crc_q,
    output logic      busy
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [CNT_W-1:0] cnt_q;
    crc_word_t        stepped;

    crc16r_step #(.POLY(POLY)) u_step (
        .cur(crc_q),
        .nxt(stepped)
    );

    assign busy = (cnt_q != '0);

    // register update: preset, byte load, or one shift step
    always_ff @(posedge clk) begin
        if (!rst_n || sof) begin
            crc_q <= PRESET;
            cnt_q <= '0;
        end else if (accept) begin
            crc_q <= crc_q ^ {{(CRC_W-BYTE_W){1'b0}}, data};
            cnt_q <= CNT_W'(BYTE_W);
        end else if (busy) begin
            crc_q <= stepped;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R5
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sof) |=> busy);

    // R5
    busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sof) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R7
    sof_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (crc_q == PRESET && !busy));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !sof && !busy) |=> $stable(crc_q));
endmodule

// File: rtl/crc16r_par_core.sv
// Unrolled register: a whole byte is folded in on the accepting edge.
// Never busy. Assumes sof has priority over accept.
module crc16r_par_core
    import crc16r_pkg::*;
#(
    parameter crc_word_t POLY   = 16'hA001,
    parameter crc_word_t PRESET = 16'hFFFF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sof,
    input  logic      accept,
    input  byte_t     data,
    output crc_word_t crc_q,
    output logic      busy
);
    crc_word_t folded;

    crc16r_unroll #(.POLY(POLY), .STEPS(BYTE_W)) u_unroll (
        .cur (crc_q),
        .data(data),
        .nxt (folded)
    );

    assign busy = 1'b0;

    // register update: preset or whole-byte fold
    always_ff @(posedge clk) begin
        if (!rst_n || sof) crc_q <= PRESET;
        else if (accept)   crc_q <= folded;
    end

    // R7
    sof_preset_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (crc_q == PRESET));

    // R10
    idle_hold_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !sof) |=> $stable(crc_q));
endmodule

// File: rtl/crc16r_engine.sv
// Top of the reflected CRC-16 generator. BIT_SERIAL selects one step per
// clock (1) or eight steps per clock (0). Outputs are final whenever ready
// is high; check bytes are presented in line order, low half first.
module crc16r_engine
    import crc16r_pkg::*;
#(
    parameter crc_word_t POLY       = 16'hA001,
    parameter crc_word_t PRESET     = 16'hFFFF,
    parameter bit        BIT_SERIAL = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        ready,
    output logic        busy,
    output logic [15:0] crc_value,
    output logic [7:0]  tx_first,
    output logic [7:0]  tx_second,
    output logic        match
);
    crc_word_t crc_w;
    logic      busy_w;
    logic      accept;

    assign ready  = !busy_w;
    assign accept = in_valid && ready && !sof;

    generate
        if (BIT_SERIAL) begin : g_serial
            crc16r_serial_core #(.POLY(POLY), .PRESET(PRESET)) u_core (
                .clk(clk), .rst_n(rst_n), .sof(sof), .accept(accept),
                .data(in_data), .crc_q(crc_w), .busy(busy_w)
            );
        end else begin : g_par
            crc16r_par_core #(.POLY(POLY), .PRESET(PRESET)) u_core (
                .clk(clk), .rst_n(rst_n), .sof(sof), .accept(accept),
                .data(in_data), .crc_q(crc_w), .busy(busy_w)
            );
        end
    endgenerate

    // output mapping: value, line-order bytes, zero-residue flag
    always_comb begin
        busy      = busy_w;
        crc_value = crc_w;
        tx_first  = crc_w[BYTE_W-1:0];
        tx_second = crc_w[CRC_W-1:BYTE_W];
        match     = !busy_w && (crc_w == '0);
    end

    // R6
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);
endmodule

// File: tb/crc16r_engine_test.sv
module crc16r_engine_test;
    import crc16r_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, sof, in_valid;
    logic [7:0]  in_data;
    logic        rdy_s, busy_s, match_s;
    logic [15:0] crc_s;
    logic [7:0]  tf_s, ts_s;
    logic        rdy_p, busy_p, match_p;
    logic [15:0] crc_p;
    logic [7:0]  tf_p, ts_p;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc16r_engine #(.BIT_SERIAL(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid), .in_data(in_data),
        .ready(rdy_s), .busy(busy_s), .crc_value(crc_s), .tx_first(tf_s),
        .tx_second(ts_s), .match(match_s)
    );

    crc16r_engine #(.BIT_SERIAL(1'b0)) uut_par (
        .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid), .in_data(in_data),
        .ready(rdy_p), .busy(busy_p), .crc_value(crc_p), .tx_first(tf_p),
        .tx_second(ts_p), .match(match_p)
    );

    function automatic logic [15:0] model(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) begin
            if (r[0]) r = (r >> 1) ^ 16'hA001;
            else      r = r >> 1;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_sof();
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, output int bcnt);
        @(negedge clk); in_valid = 1'b1; in_data = d;
        @(negedge clk); in_valid = 1'b0;
        bcnt = 0;
        while (busy_s) begin
            bcnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int bc;
        logic [15:0] e;
        rst_n = 1'b0; sof = 1'b0; in_valid = 1'b0; in_data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 crc serial", crc_s, 16'hFFFF);
        chk("R1 busy serial", busy_s, 0);
        chk("R1 ready serial", rdy_s, 1);
        chk("R1 match serial", match_s, 0);
        chk("R1 crc par", crc_p, 16'hFFFF);
        chk("R1 ready par", rdy_p, 1);

        // R2 R5 R8 R4 sweep of every single-byte frame
        for (int d = 0; d < 256; d++) begin
            pulse_sof();
            send(d[7:0], bc);
            e = model(16'hFFFF, d[7:0]);
            chk("R2 serial sweep", crc_s, e);
            chk("R8 par sweep", crc_p, e);
            chk("R8 par never busy", busy_p, 0);
            chk("R5 busy cycles", bc, 8);
            chk("R5 ready after busy", rdy_s, 1);
            chk("R4 tx_first", tf_s, e[7:0]);
            chk("R4 tx_second", ts_s, e[15:8]);
        end

        // R3 R4 known frame
        pulse_sof();
        send(8'h02, bc);
        send(8'h07, bc);
        chk("R3 serial 0207", crc_s, 16'h1241);
        chk("R3 par 0207", crc_p, 16'h1241);
        chk("R4 first byte 41", tf_s, 8'h41);
        chk("R4 second byte 12", ts_s, 8'h12);
        chk("R9 no match before check", match_s, 0);
        // R9 residue with check bytes low first
        send(8'h41, bc);
        send(8'h12, bc);
        chk("R9 residue serial", crc_s, 16'h0000);
        chk("R9 residue par", crc_p, 16'h0000);
        chk("R9 match serial", match_s, 1);
        chk("R9 match par", match_p, 1);
        // R10 hold while idle
        repeat (5) @(negedge clk);
        chk("R10 hold serial", crc_s, 16'h0000);
        chk("R10 hold par", crc_p, 16'h0000);
        chk("R10 match held", match_s, 1);

        // R6 byte offered while busy is ignored
        pulse_sof();
        @(negedge clk); in_valid = 1'b1; in_data = 8'h02;
        @(negedge clk); in_data = 8'hAA;
        chk("R6 busy when second byte offered", busy_s, 1);
        chk("R9 no match while busy", match_s, 0);
        @(negedge clk); in_valid = 1'b0;
        while (busy_s) @(negedge clk);
        chk("R6 second byte ignored", crc_s, model(16'hFFFF, 8'h02));

        // R7 sof mid-byte aborts
        pulse_sof();
        @(negedge clk); in_valid = 1'b1; in_data = 8'h05;
        @(negedge clk); in_valid = 1'b0; sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        chk("R7 abort busy", busy_s, 0);
        chk("R7 abort crc", crc_s, 16'hFFFF);
        chk("R7 abort ready", rdy_s, 1);
        // R7 sof with valid drops the byte
        @(negedge clk); sof = 1'b1; in_valid = 1'b1; in_data = 8'h33;
        @(negedge clk); sof = 1'b0; in_valid = 1'b0;
        chk("R7 dropped serial crc", crc_s, 16'hFFFF);
        chk("R7 dropped serial busy", busy_s, 0);
        chk("R7 dropped par crc", crc_p, 16'hFFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule